// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block keeps the fetch addresses of a 32-bit RISC core whose branches have one delay slot. It holds three address registers: the address of the instruction now being executed, the address that follows it, and the address of the instruction executed last. Each accepted step shifts them along. The following register is then loaded either with the sequential address four bytes on, or with the branch target captured from the instruction just executed. Because a target only enters the following register, one more instruction (the delay slot) always executes before control reaches the target.

Out of reset the block starts at a vector address. The base is the high or the low half of the address space, chosen by an exception-prefix input, and a reset offset parameter is added to it. A fetch-side breakpoint match stops one step and gives a one-cycle halt pulse. A one-shot latch then lets the next step run past the same address. When an exception is pending, the addresses still advance, but the instruction counts as not executed: its branch request is ignored and no completion pulse is given.

Top module: `pc_delay_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes the vector base plus `RST_OFFSET`, `pc_next` becomes that value plus 4, `pc_prev` becomes 0, and `delay_slot`, `halt` and `insn_done` become 0.
- R2: The vector base is 0xF0000000 when `eph` is 1 during reset, and 0x00000000 when it is 0.
- R3: On an accepted step (`step_en` high and not halted by a breakpoint), `pc_prev` takes `pc` and `pc` takes `pc_next`. Without a taken branch, `pc_next` takes its old value plus 4.
- R4: On an accepted step with `br_taken` high and no pending exception, `pc_next` takes `br_target` and `delay_slot` goes to 1. The next accepted step executes the delay-slot instruction, clears `delay_slot` and moves `pc` to the target.
- R5: A step with `bkpt_hit` high, made while the one-shot latch is clear, changes none of the address registers. It raises `halt` for exactly one cycle and sets the latch. The next step is accepted even when `bkpt_hit` is high again, and that accepted step clears the latch.
- R6: Once the latch has been cleared by an accepted step, a later step with `bkpt_hit` high halts again.
- R7: On an accepted step with `exc_pending` high, the registers still advance as in R3, but `br_taken` is ignored (`pc_next` takes old `pc_next` + 4 and `delay_slot` becomes 0), and `insn_done` stays 0.
- R8: `insn_done` is high for one cycle after each accepted step made with `exc_pending` low, and low otherwise.
- R9: With `step_en` low, all address registers and `delay_slot` hold their values.
- R10: Bits 1:0 of `pc`, `pc_next` and `pc_prev` are always 0. The low two bits of `br_target` are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eph | input | 1 | Exception-prefix select: 1 picks the high vector base |
| step_en | input | 1 | Advance one instruction |
| br_taken | input | 1 | The executing instruction takes its branch |
| br_target | input | AW | Branch target address |
| bkpt_hit | input | 1 | Breakpoint matched at the fetch address |
| exc_pending | input | 1 | Exception pending: the instruction is not executed |
| pc | output | AW | Address of the executing instruction |
| pc_next | output | AW | Address of the following instruction |
| pc_prev | output | AW | Address of the instruction executed last |
| delay_slot | output | 1 | The executing instruction sits in a delay slot |
| halt | output | 1 | One-cycle pulse: a step was stopped by a breakpoint |
| insn_done | output | 1 | One-cycle pulse: an instruction was executed |

## Verification
The bench builds the block with `RST_OFFSET` set to 0x180 rather than the default. This shows that the reset address comes from the parameter and is not hard-wired, and it is checked with both values of the prefix input. Targets with nonzero low bits exercise the alignment rule. A run of three breakpoint hits, steps that carry a branch request while an exception is pending, and idle cycles between steps reach the one-shot latch and the suppression paths.

// File: rtl/pc_delay_seq.sv
module pc_delay_seq #(
  parameter int          AW         = 32,
  parameter logic [31:0] HI_BASE    = 32'hF000_0000,
  parameter logic [31:0] RST_OFFSET = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eph,
  input  logic          step_en,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          bkpt_hit,
  input  logic          exc_pending,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] pc_prev,
  output logic          delay_slot,
  output logic          halt,
  output logic          insn_done
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic          brk_armed;
  logic [AW-1:0] vec_base, rst_pc, tgt_al;
  logic          fire, adv, take;

  assign vec_base = eph ? AW'(HI_BASE) : '0;
  assign rst_pc   = (vec_base + AW'(RST_OFFSET)) & ~AW'(3);
  assign tgt_al   = {br_target[AW-1:2], 2'b00};
  assign fire     = step_en && bkpt_hit && !brk_armed;
  assign adv      = step_en && !fire;
  assign take     = br_taken && !exc_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= rst_pc;
      pc_next    <= rst_pc + STEP;
      pc_prev    <= '0;
      delay_slot <= 1'b0;
      halt       <= 1'b0;
      insn_done  <= 1'b0;
      brk_armed  <= 1'b0;
    end else begin
      halt      <= fire;
      insn_done <= adv && !exc_pending;
      if (step_en) brk_armed <= fire;
      if (adv) begin
        pc_prev    <= pc;
        pc         <= pc_next;
        pc_next    <= take ? tgt_al : pc_next + STEP;
        delay_slot <= take;
      end
    end
  end
endmodule

module pc_delay_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          step_en,
  input logic          br_taken,
  input logic          bkpt_hit,
  input logic          exc_pending,
  input logic          brk_armed,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] pc_next,
  input logic [AW-1:0] pc_prev,
  input logic          delay_slot,
  input logic          halt,
  input logic          insn_done
);
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (step_en && !(bkpt_hit && !brk_armed)) |=> (pc == $past(pc_next) && pc_prev == $past(pc)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    halt |-> (pc == $past(pc) && pc_next == $past(pc_next) && pc_prev == $past(pc_prev)));

  a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
    halt |=> !halt);

  a_r4_delay_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(delay_slot) |-> $past(step_en && br_taken && !exc_pending));

  a_r7_no_done: assert property (@(posedge clk) disable iff (rst)
    (step_en && exc_pending) |=> !insn_done);

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pc) && $stable(pc_next) && $stable(delay_slot)));

  a_r10_align: assert property (@(posedge clk) disable iff (rst)
    (pc[1:0] == 2'b00 && pc_next[1:0] == 2'b00 && pc_prev[1:0] == 2'b00));
endmodule

bind pc_delay_seq pc_delay_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .br_taken(br_taken),
  .bkpt_hit(bkpt_hit), .exc_pending(exc_pending), .brk_armed(brk_armed),
  .pc(pc), .pc_next(pc_next), .pc_prev(pc_prev), .delay_slot(delay_slot),
  .halt(halt), .insn_done(insn_done)
);

// File: tb/test_pc_delay_seq.sv
module test_pc_delay_seq;
  logic        clk = 0, rst = 1, eph = 0, step_en = 0, br_taken = 0;
  logic        bkpt_hit = 0, exc_pending = 0;
  logic [31:0] br_target = '0;
  logic [31:0] pc, pc_next, pc_prev;
  logic        delay_slot, halt, insn_done;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pc_delay_seq #(.AW(32), .RST_OFFSET(32'h180)) i_pc_delay_seq (
    .clk(clk), .rst(rst), .eph(eph), .step_en(step_en), .br_taken(br_taken),
    .br_target(br_target), .bkpt_hit(bkpt_hit), .exc_pending(exc_pending),
    .pc(pc), .pc_next(pc_next), .pc_prev(pc_prev), .delay_slot(delay_slot),
    .halt(halt), .insn_done(insn_done));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic e);
    @(negedge clk);
    rst = 1; eph = e;
    @(posedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic step(input logic tk, input logic [31:0] tgt, input logic bk, input logic ex);
    step_en = 1; br_taken = tk; br_target = tgt; bkpt_hit = bk; exc_pending = ex;
    @(posedge clk); @(negedge clk);
    step_en = 0; br_taken = 0; bkpt_hit = 0; exc_pending = 0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 pc", pc, 32'h180);
    chk("R1 pc_next", pc_next, 32'h184);
    chk("R1 pc_prev", pc_prev, 32'h0);
    chk("R1 flags", {29'b0, delay_slot, halt, insn_done}, 32'h0);
    do_reset(1'b1);
    chk("R2 high base pc", pc, 32'hF000_0180);
    chk("R2 high base next", pc_next, 32'hF000_0184);
    do_reset(1'b0);
    chk("R2 low base pc", pc, 32'h180);
  endtask

  task automatic t_seq;
    step(0, '0, 0, 0);
    chk("R3 pc", pc, 32'h184);
    chk("R3 next", pc_next, 32'h188);
    chk("R3 prev", pc_prev, 32'h180);
    chk("R8 done pulse", {31'b0, insn_done}, 32'h1);
    @(negedge clk);
    chk("R8 done low", {31'b0, insn_done}, 32'h0);
    chk("R9 idle pc", pc, 32'h184);
    chk("R9 idle next", pc_next, 32'h188);
  endtask

  task automatic t_branch;
    step(0, '0, 0, 0);
    step(1, 32'h0000_1003, 0, 0);
    chk("R4 pc delay slot", pc, 32'h18C);
    chk("R10 R4 next target", pc_next, 32'h1000);
    chk("R4 delay flag set", {31'b0, delay_slot}, 32'h1);
    step(0, '0, 0, 0);
    chk("R4 pc at target", pc, 32'h1000);
    chk("R4 prev delay slot", pc_prev, 32'h18C);
    chk("R4 delay flag clear", {31'b0, delay_slot}, 32'h0);
    chk("R4 next seq", pc_next, 32'h1004);
  endtask

  task automatic t_bkpt;
    step(0, '0, 1, 0);
    chk("R5 halt pulse", {31'b0, halt}, 32'h1);
    chk("R5 pc held", pc, 32'h1000);
    chk("R5 no done", {31'b0, insn_done}, 32'h0);
    @(negedge clk);
    chk("R5 halt one cycle", {31'b0, halt}, 32'h0);
    step(0, '0, 1, 0);
    chk("R5 resume pc", pc, 32'h1004);
    chk("R5 resume no halt", {31'b0, halt}, 32'h0);
    step(0, '0, 1, 0);
    chk("R6 halts again", {31'b0, halt}, 32'h1);
    chk("R6 pc held", pc, 32'h1004);
    step(0, '0, 0, 0);
    chk("R6 plain step", pc, 32'h1008);
    step(0, '0, 1, 0);
    chk("R6 halt after clear", {31'b0, halt}, 32'h1);
    step(0, '0, 0, 0);
  endtask

  task automatic t_exc;
    do_reset(1'b0);
    step(1, 32'h0000_2000, 0, 1);
    chk("R7 pc advances", pc, 32'h184);
    chk("R7 branch ignored", pc_next, 32'h188);
    chk("R7 no delay", {31'b0, delay_slot}, 32'h0);
    chk("R7 no done", {31'b0, insn_done}, 32'h0);
    step(0, '0, 0, 0);
    chk("R8 done after exc", {31'b0, insn_done}, 32'h1);
  endtask

  initial begin
    fork
      begin
        t_reset; t_seq; t_branch; t_bkpt; t_exc;
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule